// File: doc/BRIEF.md
# Electrical Idle Inference Detector

This block sits on a single receive lane of a serial link. It decides that the far end has gone electrically idle even though no explicit idle indication arrived. It does this by timing the gap since the last expected receive event. A 3-bit rule select picks which event type is watched and whether the gap is counted in microsecond ticks or unit-interval ticks. A rate select changes the window length for one rule.

When the window runs out with no watched event, the block emits a single-clock inferred-idle pulse and sets a sticky flag. The flag stays set until reset, or until the rule or the rate changes. Each watched event restarts the window. Strobes for event types that the active rule does not watch are ignored.

Top module: `eidle_infer`

## Requirements
- R1: While `rule_sel[2]` is 0 (rule 0xx), inference is off. From the next clock on, `idle_pulse` and `idle_flag` are 0 and the window counter is zero.
- R2: Rule 3'b100 watches `com_skp_seen` and counts `us_tick`. After 128 ticks with no COM/SKP strobe, it infers idle. This holds at either rate.
- R3: Rule 3'b101 watches `ts_seen` and counts `ui_tick`. After 1280 ticks with no TS1/TS2 strobe, it infers idle. This holds at either rate.
- R4: Rule 3'b110 with `gen2`=0 watches `eidle_exit_seen` and counts `ui_tick`. Its window is 2000 ticks.
- R5: Rule 3'b110 with `gen2`=1 uses a window of 16000 `ui_tick` ticks.
- R6: Rule 3'b111 watches `eidle_exit_seen` and counts `us_tick`. Its window is 128 ticks.
- R7: A strobe of the watched event restarts the window from zero. Strobes of the other two event types have no effect.
- R8: Only the tick kind that belongs to the active rule advances the window. The other tick kind is ignored. The counter never goes above 16000.
- R9: The tick that completes the window raises `idle_pulse` for exactly one clock, starting on the clock after that tick. `idle_flag` is set at the same clock. The counter then holds, giving no further pulses, until a watched event restarts it.
- R10: A change of `rule_sel` or `gen2` between two clocks clears the counter and `idle_flag` on the next clock. The new window starts from zero.
- R11: Synchronous active-high `rst` clears the counter, `idle_pulse` and `idle_flag`.
- R12: If a watched event arrives in the same cycle as the window-completing tick, no idle is reported and the window restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rule_sel | input | 3 | Inference rule select |
| gen2 | input | 1 | 1 = second-generation rate |
| com_skp_seen | input | 1 | COM/SKP ordered set received this cycle |
| ts_seen | input | 1 | TS1/TS2 ordered set received this cycle |
| eidle_exit_seen | input | 1 | Electrical-idle exit detected this cycle |
| ui_tick | input | 1 | Unit-interval time tick |
| us_tick | input | 1 | Microsecond time tick |
| idle_pulse | output | 1 | One-clock inferred-idle pulse |
| idle_flag | output | 1 | Sticky inferred-idle status |

## Verification
The hardest case to reach is the collision in R12. In it, the watched event must land exactly on the tick that would complete a 1280-tick window. The stimulus first restarts the window with a strobe at a known cycle. It then drives a tick on every clock, so the window completes on a cycle the bench can compute, and places the strobe on that cycle. The second-generation 16000-tick window is run to completion in full. A rate flip mid-window shows that the count restarts and does not carry over.

// File: rtl/eidle_infer.sv
module eidle_infer #(
  parameter int US_WIN  = 128,
  parameter int TS_WIN  = 1280,
  parameter int EXIT_G1 = 2000,
  parameter int EXIT_G2 = 16000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rule_sel,
  input  logic       gen2,
  input  logic       com_skp_seen,
  input  logic       ts_seen,
  input  logic       eidle_exit_seen,
  input  logic       ui_tick,
  input  logic       us_tick,
  output logic       idle_pulse,
  output logic       idle_flag
);
  localparam int LIM_A   = (US_WIN > TS_WIN) ? US_WIN : TS_WIN;
  localparam int LIM_B   = (EXIT_G1 > EXIT_G2) ? EXIT_G1 : EXIT_G2;
  localparam int LIM_MAX = (LIM_A > LIM_B) ? LIM_A : LIM_B;
  localparam int CW      = $clog2(LIM_MAX + 1);

  logic [2:0]    rule_q;
  logic          gen2_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic          watch_evt;
  logic          adv;

  always_comb begin
    watch_evt = 1'b0;
    adv       = 1'b0;
    limit     = '0;
    case (rule_sel)
      3'b100: begin watch_evt = com_skp_seen;    adv = us_tick; limit = CW'(US_WIN); end
      3'b101: begin watch_evt = ts_seen;         adv = ui_tick; limit = CW'(TS_WIN); end
      3'b110: begin watch_evt = eidle_exit_seen; adv = ui_tick;
                    limit = gen2 ? CW'(EXIT_G2) : CW'(EXIT_G1); end
      3'b111: begin watch_evt = eidle_exit_seen; adv = us_tick; limit = CW'(US_WIN); end
      default: ;
    endcase
  end

  wire           restart = !rule_sel[2] || (rule_sel != rule_q) || (gen2 != gen2_q);
  wire [CW-1:0]  cnt_inc = cnt + 1'b1;
  wire           counting = adv && (cnt < limit);
  wire           hit      = counting && (cnt_inc == limit);

  always_ff @(posedge clk) begin
    rule_q <= rule_sel;
    gen2_q <= gen2;
    if (rst || restart) begin
      cnt        <= '0;
      idle_pulse <= 1'b0;
      idle_flag  <= 1'b0;
    end else if (watch_evt) begin
      cnt        <= '0;
      idle_pulse <= 1'b0;
    end else begin
      idle_pulse <= hit;
      if (counting) cnt <= cnt_inc;
      if (hit) idle_flag <= 1'b1;
    end
  end
endmodule

module eidle_infer_chk #(
  parameter int CW      = 14,
  parameter int CNT_MAX = 16000
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    rule_sel,
  input logic          gen2,
  input logic          com_skp_seen,
  input logic          ts_seen,
  input logic          eidle_exit_seen,
  input logic          idle_pulse,
  input logic          idle_flag,
  input logic [CW-1:0] cnt
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rule_sel[2] |=> (!idle_pulse && !idle_flag && cnt == '0)); // R1
  AST_COM_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rule_sel == 3'b100 && com_skp_seen) |=> (!idle_pulse && cnt == '0)); // R7
  AST_EXIT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rule_sel[2:1] == 2'b11 && eidle_exit_seen) |=> (!idle_pulse && cnt == '0)); // R7
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(CNT_MAX)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |=> !idle_pulse); // R9
  AST_PULSE_FLAG: assert property (@(posedge clk) disable iff (rst)
    idle_pulse |-> idle_flag); // R9
  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rule_sel != $past(rule_sel) || gen2 != $past(gen2)) |=> (cnt == '0 && !idle_flag)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!idle_pulse && !idle_flag && cnt == '0)); // R11
  AST_TS_WINS: assert property (@(posedge clk) disable iff (rst)
    (rule_sel == 3'b101 && ts_seen) |=> (!idle_pulse && cnt == '0)); // R12
endmodule

bind eidle_infer eidle_infer_chk #(.CW(CW), .CNT_MAX(LIM_MAX)) u_chk (.*);

// File: tb/eidle_infer_tb.sv
`timescale 1ns/1ps
module eidle_infer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] rule_sel = 3'b000;
  logic gen2 = 1'b0;
  logic com_skp_seen = 1'b0, ts_seen = 1'b0, eidle_exit_seen = 1'b0;
  logic ui_tick = 1'b0, us_tick = 1'b0;
  logic idle_pulse, idle_flag;

  always #2.5 clk = ~clk;

  eidle_infer u_dut (.*);

  int checks = 0, fails = 0;
  string cur_req = "R11";
  int pulses = 0;

  // reference model state
  int m_cnt = 0, m_pulse = 0, m_flag = 0;
  int m_prev_rule = 0, m_prev_gen = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    int lim, watched, tk;
    lim = 0; watched = 0; tk = 0;
    if (rule_sel == 3'd4) begin lim = 128;  watched = com_skp_seen;    tk = us_tick; end
    if (rule_sel == 3'd5) begin lim = 1280; watched = ts_seen;         tk = ui_tick; end
    if (rule_sel == 3'd6) begin lim = gen2 ? 16000 : 2000; watched = eidle_exit_seen; tk = ui_tick; end
    if (rule_sel == 3'd7) begin lim = 128;  watched = eidle_exit_seen; tk = us_tick; end
    if (rst || rule_sel < 4 || int'(rule_sel) != m_prev_rule || int'(gen2) != m_prev_gen) begin
      m_cnt = 0; m_pulse = 0; m_flag = 0;
    end else if (watched != 0) begin
      m_cnt = 0; m_pulse = 0;
    end else if (tk != 0 && m_cnt < lim) begin
      m_cnt++;
      m_pulse = (m_cnt == lim) ? 1 : 0;
      if (m_pulse != 0) m_flag = 1;
    end else m_pulse = 0;
    m_prev_rule = int'(rule_sel);
    m_prev_gen  = int'(gen2);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #1;
    chk(int'(idle_pulse) == m_pulse, {cur_req, " pulse"}, int'(idle_pulse), m_pulse);
    chk(int'(idle_flag) == m_flag, {cur_req, " flag"}, int'(idle_flag), m_flag);
    if (idle_pulse) pulses++;
  endtask

  // periods of 0 mean never; strobe on the last cycle of each period
  task automatic run(input int n, input int ui_p, input int us_p,
                     input int com_p, input int ts_p, input int ex_p);
    for (int i = 0; i < n; i++) begin
      ui_tick         = (ui_p  > 0) && (i % ui_p  == ui_p  - 1);
      us_tick         = (us_p  > 0) && (i % us_p  == us_p  - 1);
      com_skp_seen    = (com_p > 0) && (i % com_p == com_p - 1);
      ts_seen         = (ts_p  > 0) && (i % ts_p  == ts_p  - 1);
      eidle_exit_seen = (ex_p  > 0) && (i % ex_p  == ex_p  - 1);
      step();
    end
    {ui_tick, us_tick, com_skp_seen, ts_seen, eidle_exit_seen} = '0;
  endtask

  task automatic set_mode(input logic [2:0] r, input logic g);
    rule_sel = r; gen2 = g; pulses = 0;
    step();
  endtask

  initial begin
    #200000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    cur_req = "R11";
    #1;
    repeat (3) step();
    chk(!idle_pulse && !idle_flag, "R11 reset outputs", int'(idle_flag), 0);
    rst = 1'b0;

    // R1 disabled rules: ticks and strobes never produce idle
    cur_req = "R1"; set_mode(3'b011, 1'b0);
    run(3000, 1, 1, 0, 0, 0);
    rule_sel = 3'b001; run(200, 1, 1, 0, 0, 0);
    chk(pulses == 0, "R1 no pulse while off", pulses, 0);

    // R2 COM/SKP over 128 us, gen1 and gen2; ui ticks ignored (R8)
    cur_req = "R2"; set_mode(3'b100, 1'b0);
    run(128 * 4 + 20, 1, 4, 0, 0, 0);
    chk(pulses == 1, "R2 gen1 one pulse", pulses, 1);
    cur_req = "R2"; set_mode(3'b100, 1'b1);
    run(128 * 3 + 10, 0, 3, 0, 0, 0);
    chk(pulses == 1, "R2 gen2 one pulse", pulses, 1);

    // R7 watched COM/SKP keeps restarting; TS and exit strobes ignored
    cur_req = "R7"; set_mode(3'b101, 1'b0); set_mode(3'b100, 1'b0);
    run(2000, 0, 2, 200, 0, 0);
    chk(pulses == 0, "R7 watched strobe restarts", pulses, 0);
    run(300, 0, 2, 0, 7, 11);
    chk(pulses == 1, "R7 foreign strobes ignored", pulses, 1);

    // R3 TS over 1280 UI; us ticks ignored (R8)
    cur_req = "R3"; set_mode(3'b101, 1'b0);
    run(1300, 1, 1, 0, 0, 0);
    chk(pulses == 1, "R3 window 1280", pulses, 1);

    // R8 only us ticks in a UI rule: never fires
    cur_req = "R8"; set_mode(3'b110, 1'b0);
    run(2500, 0, 1, 0, 0, 0);
    chk(pulses == 0, "R8 wrong tick ignored", pulses, 0);

    // R4 exit over 2000 UI at gen1
    cur_req = "R4"; set_mode(3'b111, 1'b0); set_mode(3'b110, 1'b0);
    run(2010, 1, 0, 0, 0, 0);
    chk(pulses == 1, "R4 window 2000", pulses, 1);

    // R9 counter holds, flag sticky, refire after event
    cur_req = "R9";
    run(500, 1, 0, 0, 0, 0);
    chk(pulses == 1 && idle_flag, "R9 hold no refire", pulses, 1);
    run(2010, 1, 0, 0, 0, 2010 * 2);
    eidle_exit_seen = 1'b1; step(); eidle_exit_seen = 1'b0;
    chk(idle_flag, "R9 flag sticky across event", int'(idle_flag), 1);
    run(2005, 1, 0, 0, 0, 0);
    chk(pulses == 2, "R9 refire after event", pulses, 2);

    // R5 gen2 window 16000; R10 rate flip mid-window restarts
    cur_req = "R10"; set_mode(3'b110, 1'b1);
    run(1500, 1, 0, 0, 0, 0);
    gen2 = 1'b0; step();
    chk(!idle_flag, "R10 flag cleared on change", int'(idle_flag), 0);
    run(1999, 1, 0, 0, 0, 0);
    chk(pulses == 0, "R10 window restarted", pulses, 0);
    cur_req = "R5"; set_mode(3'b110, 1'b1);
    run(15999, 1, 0, 0, 0, 0);
    chk(pulses == 0, "R5 not before 16000", pulses, 0);
    run(5, 1, 0, 0, 0, 0);
    chk(pulses == 1, "R5 window 16000", pulses, 1);

    // R6 exit over 128 us
    cur_req = "R6"; set_mode(3'b111, 1'b0);
    run(128 * 2 + 6, 1, 2, 0, 0, 0);
    chk(pulses == 1, "R6 window 128 us", pulses, 1);

    // R12 event and completing tick in the same cycle
    cur_req = "R12"; set_mode(3'b101, 1'b0);
    ts_seen = 1'b1; step(); ts_seen = 1'b0;
    run(1279, 1, 0, 0, 0, 0);
    ui_tick = 1'b1; ts_seen = 1'b1; step(); ui_tick = 1'b0; ts_seen = 1'b0;
    step();
    chk(pulses == 0 && !idle_flag, "R12 event wins", pulses, 0);
    run(1281, 1, 0, 0, 0, 0);
    chk(pulses == 1, "R12 window restarted", pulses, 1);

    // R11 reset mid-window
    cur_req = "R11"; set_mode(3'b101, 1'b0);
    run(1000, 1, 0, 0, 0, 0);
    rst = 1'b1; step(); rst = 1'b0;
    run(1279, 1, 0, 0, 0, 0);
    chk(pulses == 0, "R11 reset restarts window", pulses, 0);
    run(3, 1, 0, 0, 0, 0);
    chk(pulses == 1, "R11 full window after reset", pulses, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule